// File: doc/BRIEF.md
# Parallel Printer Port Host Controller

This block sits between a host bus and a parallel printer. The host writes a byte to a data offset, and that byte drives the printer data lines. The host then writes to a second offset to pull the active-low strobe low, and to a third offset to release it. Two separate register writes form the strobe pulse, so its width is set by the host's own write spacing.

Completion of each byte is reported by a sticky acknowledge flag. The flag is set by a falling edge on the printer's active-low acknowledge line, and it is cleared by the write that asserts strobe. After sending a byte, the host polls the status offset until the flag is set, and only then loads the next byte. The status word also carries the printer's BUSY level after synchronisation. Both printer inputs cross into the controller clock domain through flop synchronisers before any logic uses them.

The bus is a single-cycle port with a chip select, a write enable, a 3-bit address and 8-bit data. Reads have no side effects.

Top module: `pport_host_ctrl`

## Requirements
- R1: While reset is active and after it is released, the strobe output is high (1), the data lines are 0x00, status bit 0 (acknowledge flag) reads 1 and status bit 1 reads 0 while BUSY is low.
- R2: A write to offset 1 puts the written byte on the data lines from the next clock edge, and the byte is held until the next write to offset 1.
- R3: A write to offset 2 drives the strobe output low from the next clock edge, whatever the value on the write data bus.
- R4: A write to offset 2 clears the acknowledge flag (status bit 0 reads 0 after that edge), unless R8 applies.
- R5: A write to offset 4 returns the strobe output high from the next clock edge and leaves the acknowledge flag unchanged.
- R6: A high-to-low transition on the acknowledge input sets the acknowledge flag three clock edges later. The flag stays set after the input returns high.
- R7: A read (select high, write enable low) at offset 1 returns the acknowledge flag in bit 0, the BUSY level in bit 1 two clock edges after the pin changes, and zero in bits 7..2. A read at any other offset returns 0x00.
- R8: If a strobe-assert write and a synchronised acknowledge falling edge land on the same clock edge, the flag ends set.
- R9: Writes to offsets 0, 3, 5, 6 and 7, writes to offset 1, and all reads leave the strobe output and the acknowledge flag unchanged. Writes to offsets other than 1 leave the data lines unchanged.
- R10: An acknowledge input that is held low does not set the flag again after a clear, and a rising edge on it never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_cs | input | 1 | Bus select for one cycle |
| bus_we | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational for the current read |
| lp_data | output | 8 | Printer data lines |
| lp_strobe_n | output | 1 | Printer strobe, active low |
| lp_ack_n | input | 1 | Printer acknowledge, active low, asynchronous |
| lp_busy | input | 1 | Printer busy, asynchronous |

## Verification
The hardest case to reach is the collision of R8. A strobe-assert write has to arrive on the exact edge at which the synchronised acknowledge edge is recognised, which is a window one cycle wide that sits behind two synchroniser stages. The stimulus drops the acknowledge input at a known falling clock edge, counts two rising edges, and then presents the strobe write in the following cycle, so both events meet on the third edge. A second hard case is an acknowledge input held low across a clear (R10). The bench reaches it by leaving the input low through a full strobe cycle and polling the status.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LOAD    = 3'd1,
    OP_STB_ON  = 3'd2,
    OP_STB_OFF = 3'd3,
    OP_STAT_RD = 3'd4,
    OP_OTHER   = 3'd5
  } bus_op_e;

  localparam int unsigned STAT_ACK_BIT  = 0;
  localparam int unsigned STAT_BUSY_BIT = 1;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned  WIDTH   = 1,
  parameter int unsigned  STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stg[i-1].q;
      end
    end
  end

  assign dout = g_stg[STAGES-1].q;

endmodule

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int unsigned     AW          = 3,
  parameter logic [AW-1:0]   OFF_LOAD    = 1,
  parameter logic [AW-1:0]   OFF_STB_ON  = 2,
  parameter logic [AW-1:0]   OFF_STB_OFF = 4,
  parameter logic [AW-1:0]   OFF_STATUS  = 1
) (
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output bus_op_e       op
);

  always_comb begin
    op = OP_IDLE;
    if (cs) begin
      if (we) begin
        if      (addr == OFF_LOAD)    op = OP_LOAD;
        else if (addr == OFF_STB_ON)  op = OP_STB_ON;
        else if (addr == OFF_STB_OFF) op = OP_STB_OFF;
        else                          op = OP_OTHER;
      end else begin
        if (addr == OFF_STATUS) op = OP_STAT_RD;
        else                    op = OP_OTHER;
      end
    end
  end

endmodule

// File: rtl/pport_out_regs.sv
module pport_out_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          stb_on,
  input  logic          stb_off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_q,
  output logic          strobe_n_q
);

  logic [DW-1:0] data_d;
  logic          strobe_n_d;
  logic          strobe_en;

  always_comb begin
    data_d     = wdata;
    strobe_en  = stb_on | stb_off;
    strobe_n_d = ~stb_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         strobe_n_q <= 1'b1;
    else if (strobe_en) strobe_n_q <= strobe_n_d;
  end

endmodule

// File: rtl/pport_ack_latch.sv
module pport_ack_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_s,
  input  logic clr,
  output logic fall,
  output logic flag_q
);

  logic prev_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    fall    = prev_q & ~ack_n_s;
    flag_en = fall | clr;
    flag_d  = fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= ack_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (flag_en) flag_q <= flag_d;
  end

endmodule

// File: rtl/pport_host_ctrl.sv
module pport_host_ctrl
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] OFF_LOAD    = 1,
  parameter logic [ADDR_W-1:0] OFF_STB_ON  = 2,
  parameter logic [ADDR_W-1:0] OFF_STB_OFF = 4,
  parameter logic [ADDR_W-1:0] OFF_STATUS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] lp_data,
  output logic              lp_strobe_n,
  input  logic              lp_ack_n,
  input  logic              lp_busy
);

  localparam int unsigned PIN_W = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_chain_q [RST_STAGES];
  logic rst_sync_n;

  for (genvar i = 0; i < RST_STAGES; i++) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_chain_q[i] <= 1'b0;
      else        rst_chain_q[i] <= (i == 0) ? 1'b1 : rst_chain_q[(i == 0) ? 0 : i-1];
    end
  end
  assign rst_sync_n = rst_chain_q[RST_STAGES-1];

  // printer inputs into the clock domain; index 0 = ack_n, 1 = busy
  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             ack_n_s;
  logic             busy_s;

  assign pins_raw = {lp_busy, lp_ack_n};

  pport_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b01)
  ) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  assign ack_n_s = pins_s[0];
  assign busy_s  = pins_s[1];

  bus_op_e op;

  pport_decode #(
    .AW         (ADDR_W),
    .OFF_LOAD   (OFF_LOAD),
    .OFF_STB_ON (OFF_STB_ON),
    .OFF_STB_OFF(OFF_STB_OFF),
    .OFF_STATUS (OFF_STATUS)
  ) u_decode (
    .cs  (bus_cs),
    .we  (bus_we),
    .addr(bus_addr),
    .op  (op)
  );

  logic op_load;
  logic op_stb_on;
  logic op_stb_off;
  logic op_stat_rd;

  assign op_load    = (op == OP_LOAD);
  assign op_stb_on  = (op == OP_STB_ON);
  assign op_stb_off = (op == OP_STB_OFF);
  assign op_stat_rd = (op == OP_STAT_RD);

  pport_out_regs #(
    .DW(DATA_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (op_load),
    .stb_on    (op_stb_on),
    .stb_off   (op_stb_off),
    .wdata     (bus_wdata),
    .data_q    (lp_data),
    .strobe_n_q(lp_strobe_n)
  );

  logic ack_fall;
  logic ack_flag;

  pport_ack_latch u_ack (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ack_n_s(ack_n_s),
    .clr    (op_stb_on),
    .fall   (ack_fall),
    .flag_q (ack_flag)
  );

  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word                = '0;
    status_word[STAT_ACK_BIT]  = ack_flag;
    status_word[STAT_BUSY_BIT] = busy_s;
    bus_rdata                  = op_stat_rd ? status_word : '0;
  end

endmodule

// File: rtl/pport_checker.sv
module pport_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] lp_data,
  input logic              lp_strobe_n,
  input logic              ack_fall,
  input logic              ack_flag
);

  logic wr_load, wr_on, wr_off;
  assign wr_load = bus_cs && bus_we && (bus_addr == ADDR_W'(1));
  assign wr_on   = bus_cs && bus_we && (bus_addr == ADDR_W'(2));
  assign wr_off  = bus_cs && bus_we && (bus_addr == ADDR_W'(4));

  assert_load_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> lp_data == $past(bus_wdata));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load |=> $stable(lp_data));

  assert_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_on |=> !lp_strobe_n);

  assert_strobe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> lp_strobe_n);

  assert_strobe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_on && !wr_off) |=> $stable(lp_strobe_n));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on && !ack_fall) |=> !ack_flag);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |=> ack_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_flag && !wr_on) |=> ack_flag);

  assert_status_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:2] == '0);

endmodule

bind pport_host_ctrl pport_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_pport_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_cs     (bus_cs),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .lp_data    (lp_data),
  .lp_strobe_n(lp_strobe_n),
  .ack_fall   (ack_fall),
  .ack_flag   (ack_flag)
);

// File: tb/test_pport_host_ctrl.sv
`timescale 1ns/1ps
module test_pport_host_ctrl;

  logic       clk;
  logic       rst_n;
  logic       bus_cs;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] lp_data;
  logic       lp_strobe_n;
  logic       lp_ack_n;
  logic       lp_busy;

  pport_host_ctrl i_pport_host_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lp_data(lp_data), .lp_strobe_n(lp_strobe_n),
    .lp_ack_n(lp_ack_n), .lp_busy(lp_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // kind: 0 = read data, 1 = printer data lines, 2 = strobe
  typedef struct {
    int       kind;
    logic [7:0] exp;
    string    req;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: compares just before the next rising edge
  always begin
    @(negedge clk);
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = lp_data;
        default: act = {7'd0, lp_strobe_n};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h at %0t",
                 it.req, it.kind, act, it.exp, $time);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  // read issued in the current cycle; caller sits on a falling edge
  task automatic read_at(input logic [2:0] a, input logic [7:0] exp, input string req);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    push(0, exp, req);
    @(negedge clk);
    bus_cs = 1'b0;
  endtask

  task automatic expect_pins(input logic [7:0] d, input logic s, input string req);
    push(1, d, req);
    push(2, {7'd0, s}, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    lp_ack_n = 1'b1; lp_busy = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    expect_pins(8'h00, 1'b1, "R1");
    read_at(3'd1, 8'h01, "R1");

    // R2 load, R9 flag untouched by load
    bus_write(3'd1, 8'hA5);
    expect_pins(8'hA5, 1'b1, "R2");
    read_at(3'd1, 8'h01, "R9");

    // R3 / R4 strobe assert with nonzero data
    bus_write(3'd2, 8'hFF);
    expect_pins(8'hA5, 1'b0, "R3");
    read_at(3'd1, 8'h00, "R4");

    // R5 release leaves flag clear
    bus_write(3'd4, 8'h00);
    expect_pins(8'hA5, 1'b1, "R5");
    read_at(3'd1, 8'h00, "R5");

    // R7 busy latency: two edges
    lp_busy = 1'b1;
    @(negedge clk);
    read_at(3'd1, 8'h00, "R7");
    read_at(3'd1, 8'h02, "R7");
    read_at(3'd2, 8'h00, "R7");

    // R6 acknowledge pulse: set on third edge, sticky
    lp_ack_n = 1'b0;
    idle(2);
    read_at(3'd1, 8'h02, "R6");
    read_at(3'd1, 8'h03, "R6");
    lp_ack_n = 1'b1;
    lp_busy  = 1'b0;
    idle(4);
    read_at(3'd1, 8'h01, "R6");

    // R9 writes to unused offsets
    bus_write(3'd0, 8'hFF);
    bus_write(3'd3, 8'hFF);
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'hFF);
    bus_write(3'd7, 8'hFF);
    expect_pins(8'hA5, 1'b1, "R9");
    read_at(3'd1, 8'h01, "R9");
    bus_write(3'd2, 8'h00);
    bus_write(3'd7, 8'h00);
    bus_write(3'd0, 8'h3C);
    expect_pins(8'hA5, 1'b0, "R9");
    read_at(3'd1, 8'h00, "R9");
    read_at(3'd1, 8'h00, "R9");
    bus_write(3'd4, 8'h00);

    // R2 further patterns
    bus_write(3'd1, 8'h3C);
    expect_pins(8'h3C, 1'b1, "R2");
    bus_write(3'd1, 8'hC3);
    expect_pins(8'hC3, 1'b1, "R2");

    // R10 held-low acknowledge
    bus_write(3'd2, 8'h00);
    bus_write(3'd4, 8'h00);
    lp_ack_n = 1'b0;
    idle(4);
    read_at(3'd1, 8'h01, "R10");
    bus_write(3'd2, 8'h00);
    bus_write(3'd4, 8'h00);
    idle(4);
    read_at(3'd1, 8'h00, "R10");
    lp_ack_n = 1'b1;
    idle(4);
    read_at(3'd1, 8'h00, "R10");

    // R8 collision: ack recognised on the same edge as strobe write
    lp_ack_n = 1'b0;
    idle(2);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h55;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
    expect_pins(8'hC3, 1'b0, "R8");
    read_at(3'd1, 8'h01, "R8");
    lp_ack_n = 1'b1;
    bus_write(3'd4, 8'h00);

    // R1 reset mid-run
    bus_write(3'd2, 8'h00);
    do_reset();
    expect_pins(8'h00, 1'b1, "R1");
    read_at(3'd1, 8'h01, "R1");

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule